// File: doc/BRIEF.md
# Multi-Ring Circular FIFO Controller

The controller keeps sixteen independent circular FIFOs inside one shared on-chip word memory. Software, or a neighbouring engine, first creates a ring. It gives the ring number, a start address in the shared memory and one of four capacities. The controller then owns that ring's base, capacity, head and tail. Producers and consumers use one command port. A put carries up to sixteen 32-bit words that are appended to a ring. A get drains up to sixteen words from a ring and returns them one per cycle on a response stream.

Each ring reports two flags. An empty flag is raised when the ring holds no words. A near-full flag is raised at three quarters of capacity instead of at true full. Several producers can each read "not near-full" in the same window and all still fit. The true capacity is also guarded: a put that would not fit completely is dropped as a whole and reported as an error. A get on an empty ring returns no words and is reported as an error. A get that asks for more words than the ring holds returns only the words that are there.

Commands are taken one at a time through a valid/ready handshake. Each accepted command ends with exactly one done pulse, which carries the error bit.

Top module: `mring_ctrl`

## Requirements
- R1: After reset, every ring is empty with near-full low, `cmd_ready` is high, and each ring has capacity 128 words at base 0.
- R2: A configuration write sets the ring's capacity from `cfg_size`: 0 gives 128 words, 1 gives 256, 2 gives 512 and 3 gives 1024. The same write empties the ring. Base address bits below the capacity are ignored, so the ring starts at the base rounded down to a multiple of its capacity.
- R3: Words come out of a ring in the order they went in. Within a put, word i is taken from `cmd_wdata[32*i +: 32]`, so word 0 goes first.
- R4: `cmd_len` holds the burst length minus one, so bursts of 1 to 16 words are possible. `cmd_op` 0 means put and 1 means get.
- R5: Head and tail wrap at the ring capacity, and data stays intact across the wrap.
- R6: `ring_nfull[r]` is high exactly when ring r holds at least three quarters of its capacity.
- R7: `ring_empty[r]` is high exactly when ring r holds no words.
- R8: A get on an empty ring returns no response words and ends with `cmd_err` high.
- R9: A get for more words than the ring holds returns only the held words and ends with `cmd_err` low.
- R10: A put that would make the occupancy larger than the capacity writes nothing and ends with `cmd_err` high. A put that fills the ring exactly is accepted.
- R11: Rings with disjoint regions do not affect each other. Every memory write falls inside the region of the ring being served.
- R12: `cmd_ready` is high only while no command is in progress. Every accepted command produces exactly one `cmd_done` pulse, after which `cmd_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Create/recreate a ring this cycle |
| cfg_ring | input | 4 | Ring to create |
| cfg_base | input | 11 | Start word address in shared memory |
| cfg_size | input | 2 | Capacity code (128 << code words) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command taken on valid and ready |
| cmd_op | input | 1 | 0 put, 1 get |
| cmd_ring | input | 4 | Target ring |
| cmd_len | input | 4 | Burst length minus one |
| cmd_wdata | input | 512 | Put words, word 0 in the low 32 bits |
| rsp_valid | output | 1 | Get word valid |
| rsp_data | output | 32 | Get word |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| cmd_err | output | 1 | Error qualifier of `cmd_done` |
| ring_empty | output | 16 | Per-ring empty flag |
| ring_nfull | output | 16 | Per-ring three-quarter flag |

## Verification
The bench aims at the capacity edges. It fills a ring to exactly its capacity and then adds one more word. A design that compares occupancy with `>=` instead of `>` would refuse the exact fill. One without the extra wrap bit would treat the full ring as empty. It checks the near-full flag one word below and one word at the threshold, for two capacities, so that an off-by-one or a fixed threshold would show up. A ring is pushed around its wrap point, which catches an offset that is not masked to the capacity. Two rings created at an unaligned base and an aligned base are made to alias, which shows whether the low base bits are really dropped. Empty gets and gets larger than the occupancy check that the design never returns stale or extra words.

// File: rtl/mring_pkg.sv
package mring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_DRAIN = 3'd4,
    ST_DONE  = 3'd5
  } seq_st_e;

  localparam logic OP_PUT = 1'b0;
  localparam logic OP_GET = 1'b1;

endpackage

// File: rtl/mring_ram.sv
module mring_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem_q[addr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/mring_ptrs.sv
module mring_ptrs #(
  parameter int RINGS   = 16,
  parameter int AW      = 11,
  parameter int PTR_W   = 11,
  parameter int MIN_LOG = 7,
  parameter int SZC_W   = 2,
  parameter int RID_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RID_W-1:0] cfg_ring,
  input  logic [AW-1:0]    cfg_base,
  input  logic [SZC_W-1:0] cfg_szc,
  input  logic [RID_W-1:0] sel_ring,
  input  logic             adv_head,
  input  logic             adv_tail,
  output logic [AW-1:0]    sel_base,
  output logic [PTR_W-1:0] sel_head,
  output logic [PTR_W-1:0] sel_tail,
  output logic [PTR_W-1:0] sel_cap,
  output logic [PTR_W-1:0] sel_occ,
  output logic [RINGS-1:0] empty,
  output logic [RINGS-1:0] nfull
);

  logic [AW-1:0]    base_a [RINGS];
  logic [PTR_W-1:0] head_a [RINGS];
  logic [PTR_W-1:0] tail_a [RINGS];
  logic [PTR_W-1:0] cap_a  [RINGS];
  logic [PTR_W-1:0] occ_a  [RINGS];

  // capacity in words of the incoming configuration
  logic [PTR_W-1:0] cfg_cap;
  logic [AW-1:0]    cfg_base_al;
  assign cfg_cap     = PTR_W'(1) << (MIN_LOG + int'(cfg_szc));
  assign cfg_base_al = cfg_base & ~(AW'(cfg_cap) - AW'(1));

  for (genvar g = 0; g < RINGS; g++) begin : g_ring
    logic [AW-1:0]    base_q, base_d;
    logic [SZC_W-1:0] szc_q, szc_d;
    logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
    logic [PTR_W-1:0] cap, wrap_mask, occ;
    logic             hit_cfg, hit_cmd, en;

    assign cap       = PTR_W'(1) << (MIN_LOG + int'(szc_q));
    assign wrap_mask = {cap[PTR_W-2:0], 1'b0} - PTR_W'(1);
    assign occ       = (tail_q - head_q) & wrap_mask;
    assign hit_cfg   = cfg_we && (cfg_ring == RID_W'(g));
    assign hit_cmd   = (sel_ring == RID_W'(g));
    assign en        = hit_cfg || (hit_cmd && (adv_head || adv_tail));

    always_comb begin
      base_d = base_q;
      szc_d  = szc_q;
      head_d = head_q;
      tail_d = tail_q;
      if (hit_cfg) begin
        base_d = cfg_base_al;
        szc_d  = cfg_szc;
        head_d = '0;
        tail_d = '0;
      end else begin
        if (hit_cmd && adv_head) head_d = (head_q + PTR_W'(1)) & wrap_mask;
        if (hit_cmd && adv_tail) tail_d = (tail_q + PTR_W'(1)) & wrap_mask;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        szc_q  <= '0;
        head_q <= '0;
        tail_q <= '0;
      end else if (en) begin
        base_q <= base_d;
        szc_q  <= szc_d;
        head_q <= head_d;
        tail_q <= tail_d;
      end
    end

    assign base_a[g] = base_q;
    assign head_a[g] = head_q;
    assign tail_a[g] = tail_q;
    assign cap_a[g]  = cap;
    assign occ_a[g]  = occ;
    assign empty[g]  = (occ == '0);
    assign nfull[g]  = (occ >= (cap - (cap >> 2)));

    AST_OCC_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= cap); // R10
    AST_NFULL_EXCLUDES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      nfull[g] |-> !empty[g]); // R6
    AST_CFG_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cfg |=> empty[g]); // R2
  end

  assign sel_base = base_a[sel_ring];
  assign sel_head = head_a[sel_ring];
  assign sel_tail = tail_a[sel_ring];
  assign sel_cap  = cap_a[sel_ring];
  assign sel_occ  = occ_a[sel_ring];

endmodule

// File: rtl/mring_seq.sv
module mring_seq
  import mring_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DW    = 32,
  parameter int BURST = 16,
  parameter int PTR_W = 11,
  parameter int RID_W = 4,
  parameter int LEN_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [RID_W-1:0]    cmd_ring,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [BURST*DW-1:0] cmd_wdata,
  output logic [RID_W-1:0]    sel_ring,
  input  logic [AW-1:0]       sel_base,
  input  logic [PTR_W-1:0]    sel_head,
  input  logic [PTR_W-1:0]    sel_tail,
  input  logic [PTR_W-1:0]    sel_cap,
  input  logic [PTR_W-1:0]    sel_occ,
  output logic                mem_we,
  output logic                mem_re,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  output logic                adv_head,
  output logic                adv_tail,
  output logic                done,
  output logic                err
);

  localparam int CNT_W = LEN_W + 1;

  seq_st_e             st_q, st_d;
  logic                op_q, op_d;
  logic [RID_W-1:0]    ring_q, ring_d;
  logic [CNT_W-1:0]    rem_q, rem_d;
  logic [BURST*DW-1:0] data_q, data_d;
  logic                err_q, err_d;
  logic                ld_en;

  logic [PTR_W:0]      need_occ;
  logic                put_ovf;
  logic [PTR_W-1:0]    req_ext;
  logic [PTR_W-1:0]    ptr_cur;

  assign req_ext  = PTR_W'(rem_q);
  assign need_occ = {1'b0, sel_occ} + {1'b0, req_ext};
  assign put_ovf  = need_occ > {1'b0, sel_cap};

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    ring_d   = ring_q;
    rem_d    = rem_q;
    data_d   = data_q;
    err_d    = err_q;
    ld_en    = 1'b0;
    mem_we   = 1'b0;
    mem_re   = 1'b0;
    adv_head = 1'b0;
    adv_tail = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          ld_en  = 1'b1;
          op_d   = cmd_op;
          ring_d = cmd_ring;
          rem_d  = CNT_W'(cmd_len) + CNT_W'(1);
          data_d = cmd_wdata;
          err_d  = 1'b0;
          st_d   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        ld_en = 1'b1;
        if (op_q == OP_PUT) begin
          if (put_ovf) begin
            err_d = 1'b1;
            st_d  = ST_DONE;
          end else begin
            st_d = ST_WRITE;
          end
        end else begin
          if (sel_occ == '0) begin
            err_d = 1'b1;
            st_d  = ST_DONE;
          end else begin
            if (sel_occ < req_ext) rem_d = CNT_W'(sel_occ);
            st_d = ST_READ;
          end
        end
      end
      ST_WRITE: begin
        ld_en    = 1'b1;
        mem_we   = 1'b1;
        adv_tail = 1'b1;
        data_d   = data_q >> DW;
        rem_d    = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) st_d = ST_DONE;
      end
      ST_READ: begin
        ld_en    = 1'b1;
        mem_re   = 1'b1;
        adv_head = 1'b1;
        rem_d    = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) st_d = ST_DRAIN;
      end
      ST_DRAIN: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PUT;
      ring_q <= '0;
      rem_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (ld_en) begin
      op_q   <= op_d;
      ring_q <= ring_d;
      rem_q  <= rem_d;
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  assign ptr_cur   = (st_q == ST_READ) ? sel_head : sel_tail;
  assign mem_addr  = sel_base | AW'(ptr_cur & (sel_cap - PTR_W'(1)));
  assign mem_wdata = data_q[DW-1:0];
  assign sel_ring  = ring_q;
  assign cmd_ready = (st_q == ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign err       = err_q;

  AST_DONE_RETURNS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready); // R12
  AST_ERR_NOTHING_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !$past(mem_we)); // R10
  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R12
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (sel_occ != '0)); // R8

endmodule

// File: rtl/mring_ctrl.sv
module mring_ctrl #(
  parameter int RINGS    = 16,
  parameter int DW       = 32,
  parameter int AW       = 11,
  parameter int BURST    = 16,
  parameter int MIN_LOG  = 7,
  parameter int SZ_CODES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_valid,
  input  logic [$clog2(RINGS)-1:0]   cfg_ring,
  input  logic [AW-1:0]              cfg_base,
  input  logic [$clog2(SZ_CODES)-1:0] cfg_size,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_op,
  input  logic [$clog2(RINGS)-1:0]   cmd_ring,
  input  logic [$clog2(BURST)-1:0]   cmd_len,
  input  logic [BURST*DW-1:0]        cmd_wdata,
  output logic                       rsp_valid,
  output logic [DW-1:0]              rsp_data,
  output logic                       cmd_done,
  output logic                       cmd_err,
  output logic [RINGS-1:0]           ring_empty,
  output logic [RINGS-1:0]           ring_nfull
);

  localparam int RID_W = $clog2(RINGS);
  localparam int LEN_W = $clog2(BURST);
  localparam int SZC_W = $clog2(SZ_CODES);
  localparam int MAX_LOG = MIN_LOG + SZ_CODES - 1;
  localparam int PTR_W = MAX_LOG + 1;

  logic [RID_W-1:0] sel_ring;
  logic [AW-1:0]    sel_base;
  logic [PTR_W-1:0] sel_head, sel_tail, sel_cap, sel_occ;
  logic             adv_head, adv_tail;
  logic             mem_we, mem_re;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata;
  logic             rsp_valid_q;

  mring_ptrs #(
    .RINGS(RINGS), .AW(AW), .PTR_W(PTR_W), .MIN_LOG(MIN_LOG),
    .SZC_W(SZC_W), .RID_W(RID_W)
  ) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_valid),
    .cfg_ring (cfg_ring),
    .cfg_base (cfg_base),
    .cfg_szc  (cfg_size),
    .sel_ring (sel_ring),
    .adv_head (adv_head),
    .adv_tail (adv_tail),
    .sel_base (sel_base),
    .sel_head (sel_head),
    .sel_tail (sel_tail),
    .sel_cap  (sel_cap),
    .sel_occ  (sel_occ),
    .empty    (ring_empty),
    .nfull    (ring_nfull)
  );

  mring_seq #(
    .AW(AW), .DW(DW), .BURST(BURST), .PTR_W(PTR_W),
    .RID_W(RID_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_ring  (cmd_ring),
    .cmd_len   (cmd_len),
    .cmd_wdata (cmd_wdata),
    .sel_ring  (sel_ring),
    .sel_base  (sel_base),
    .sel_head  (sel_head),
    .sel_tail  (sel_tail),
    .sel_cap   (sel_cap),
    .sel_occ   (sel_occ),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .adv_head  (adv_head),
    .adv_tail  (adv_tail),
    .done      (cmd_done),
    .err       (cmd_err)
  );

  mring_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= mem_re;
    end
  end

  assign rsp_valid = rsp_valid_q;

  AST_WRITE_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr & ~AW'(sel_cap - PTR_W'(1))) == sel_base)); // R11
  AST_ERR_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_err) |-> !rsp_valid); // R8
  AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R3

endmodule

// File: tb/sim_mring_ctrl.sv
`timescale 1ns/1ps
module sim_mring_ctrl;

  localparam int BURST = 16;

  logic              clk;
  logic              rst_n;
  logic              cfg_valid;
  logic [3:0]        cfg_ring;
  logic [10:0]       cfg_base;
  logic [1:0]        cfg_size;
  logic              cmd_valid;
  logic              cmd_ready;
  logic              cmd_op;
  logic [3:0]        cmd_ring;
  logic [3:0]        cmd_len;
  logic [BURST*32-1:0] cmd_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              cmd_done;
  logic              cmd_err;
  logic [15:0]       ring_empty;
  logic [15:0]       ring_nfull;

  int total = 0;
  int bad   = 0;
  int seed_cnt = 0;
  logic [31:0] mq [16][$];
  logic [31:0] got_q [$];
  logic        last_err;

  mring_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ring(cfg_ring), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_ring(cmd_ring),
    .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .ring_empty(ring_empty), .ring_nfull(ring_nfull)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic do_cfg(input int r, input int base, input int szc);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_ring  = 4'(r);
    cfg_base  = 11'(base);
    cfg_size  = 2'(szc);
    @(negedge clk);
    cfg_valid = 1'b0;
    mq[r].delete();
  endtask

  task automatic send(input logic op, input int r, input int n, input logic [BURST*32-1:0] wd);
    bit fin;
    int dones;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_ring  = 4'(r);
    cmd_len   = 4'(n - 1);
    cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R12", "ready while busy", 32'(cmd_ready), 0);
    got_q.delete();
    fin = 0;
    dones = 0;
    do begin
      if (rsp_valid) got_q.push_back(rsp_data);
      if (cmd_done) begin
        last_err = cmd_err;
        dones++;
        fin = 1;
      end else begin
        @(negedge clk);
      end
    end while (!fin);
    @(negedge clk);
    chk(cmd_done == 1'b0 && cmd_ready == 1'b1, "R12", "single done then ready",
        {30'd0, cmd_done, cmd_ready}, 32'd1);
  endtask

  task automatic do_put(input int r, input int n, input bit exp_err, input string req);
    logic [BURST*32-1:0] wd;
    wd = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      seed_cnt++;
      w = {4'(r), 12'hA5C, 16'(seed_cnt)};
      wd[32*i +: 32] = w;
      if (!exp_err) mq[r].push_back(w);
    end
    send(1'b0, r, n, wd);
    chk(last_err == exp_err, req, "put error bit", 32'(last_err), 32'(exp_err));
    chk(got_q.size() == 0, req, "put gives no response", got_q.size(), 0);
  endtask

  task automatic do_get(input int r, input int n, input string req);
    int  held;
    int  exp_n;
    bit  exp_err;
    held    = mq[r].size();
    exp_n   = (n < held) ? n : held;
    exp_err = (held == 0);
    send(1'b1, r, n, '0);
    chk(last_err == exp_err, req, "get error bit", 32'(last_err), 32'(exp_err));
    chk(got_q.size() == exp_n, req, "get word count", got_q.size(), exp_n);
    for (int i = 0; i < exp_n; i++) begin
      logic [31:0] e;
      e = mq[r].pop_front();
      if (i < got_q.size())
        chk(got_q[i] == e, req, "get word value", got_q[i], e);
    end
  endtask

  task automatic fill(input int r, input int words, input string req);
    int left;
    left = words;
    while (left > 0) begin
      int n;
      n = (left > 16) ? 16 : left;
      do_put(r, n, 1'b0, req);
      left -= n;
    end
  endtask

  task automatic drain(input int r, input int words, input string req);
    int left;
    left = words;
    while (left > 0) begin
      int n;
      n = (left > 16) ? 16 : left;
      do_get(r, n, req);
      left -= n;
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", 32'(cmd_ready), 1);
    chk(ring_empty == 16'hFFFF, "R1", "all empty", 32'(ring_empty), 32'hFFFF);
    chk(ring_nfull == 16'h0000, "R1", "none near-full", 32'(ring_nfull), 0);
    chk(cmd_done == 1'b0, "R1", "no done at reset", 32'(cmd_done), 0);
  endtask

  // R3, R4, R7: ordering, burst lengths, empty flag
  task automatic t_basic();
    do_cfg(0, 'h000, 0);
    do_put(0, 3, 1'b0, "R3");
    @(negedge clk);
    chk(ring_empty[0] == 1'b0, "R7", "not empty after put", 32'(ring_empty[0]), 0);
    do_put(0, 16, 1'b0, "R4");
    do_put(0, 1, 1'b0, "R4");
    do_get(0, 2, "R3");
    do_get(0, 16, "R4");
    do_get(0, 2, "R3");
    @(negedge clk);
    chk(ring_empty[0] == 1'b1, "R7", "empty after drain", 32'(ring_empty[0]), 1);
  endtask

  // R2, R6: capacities and three-quarter threshold
  task automatic t_threshold();
    do_cfg(1, 'h100, 1);
    fill(1, 191, "R6");
    @(negedge clk);
    chk(ring_nfull[1] == 1'b0, "R6", "256 ring at 191", 32'(ring_nfull[1]), 0);
    do_put(1, 1, 1'b0, "R6");
    @(negedge clk);
    chk(ring_nfull[1] == 1'b1, "R6", "256 ring at 192", 32'(ring_nfull[1]), 1);
    do_get(1, 1, "R6");
    @(negedge clk);
    chk(ring_nfull[1] == 1'b0, "R6", "256 ring back to 191", 32'(ring_nfull[1]), 0);
    do_cfg(3, 'h400, 3);
    fill(3, 767, "R2");
    @(negedge clk);
    chk(ring_nfull[3] == 1'b0, "R2", "1024 ring at 767", 32'(ring_nfull[3]), 0);
    do_put(3, 1, 1'b0, "R2");
    @(negedge clk);
    chk(ring_nfull[3] == 1'b1, "R2", "1024 ring at 768", 32'(ring_nfull[3]), 1);
    do_cfg(3, 'h400, 3);
    @(negedge clk);
    chk(ring_empty[3] == 1'b1 && ring_nfull[3] == 1'b0, "R2", "recreate empties",
        {30'd0, ring_empty[3], ring_nfull[3]}, 32'd2);
  endtask

  // R2: low base bits dropped, so rings 4 and 5 alias at 0x200
  task automatic t_align();
    logic [31:0] w;
    do_cfg(4, 'h210, 0);
    do_cfg(5, 'h200, 0);
    do_put(4, 1, 1'b0, "R2");
    do_put(5, 1, 1'b0, "R2");
    w = mq[5][0];
    mq[4][0] = w;
    do_get(4, 1, "R2");
    do_get(5, 1, "R2");
  endtask

  // R5, R11: wrap and isolation from ring 0
  task automatic t_wrap();
    do_put(0, 5, 1'b0, "R11");
    do_cfg(6, 'h080, 0);
    fill(6, 100, "R5");
    drain(6, 100, "R5");
    fill(6, 60, "R5");
    drain(6, 60, "R5");
    do_get(0, 5, "R11");
  endtask

  // R8, R9: empty gets and oversize gets
  task automatic t_get_edges();
    do_cfg(7, 'h300, 0);
    do_get(7, 4, "R8");
    do_put(7, 3, 1'b0, "R9");
    do_get(7, 8, "R9");
    do_get(7, 1, "R8");
  endtask

  // R10: overflow drops whole burst, exact fill accepted
  task automatic t_overflow();
    do_cfg(8, 'h280, 0);
    fill(8, 120, "R10");
    do_put(8, 16, 1'b1, "R10");
    do_put(8, 8, 1'b0, "R10");
    do_put(8, 1, 1'b1, "R10");
    @(negedge clk);
    chk(ring_nfull[8] == 1'b1 && ring_empty[8] == 1'b0, "R10", "full ring flags",
        {30'd0, ring_nfull[8], ring_empty[8]}, 32'd2);
    drain(8, 128, "R10");
    @(negedge clk);
    chk(ring_empty[8] == 1'b1, "R10", "drained after full", 32'(ring_empty[8]), 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    cfg_valid = 1'b0;
    cfg_ring  = '0;
    cfg_base  = '0;
    cfg_size  = '0;
    cmd_valid = 1'b0;
    cmd_op    = 1'b0;
    cmd_ring  = '0;
    cmd_len   = '0;
    cmd_wdata = '0;
    last_err  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_threshold();
    t_align();
    t_wrap();
    t_get_edges();
    t_overflow();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule